// File: doc/BRIEF.md
# Chopped ADC Conversion Rate Sequencer

This block sets the output-word timing of a chopped sigma-delta converter whose main and auxiliary channels share one decimation setting. It runs in the modulator clock domain and holds an 8-bit decimation factor. The factor is written and read through a simple register port. While either channel is converting, the block counts modulator cycles and issues a one-cycle ready strobe at the end of each output period. One output period is 24 times the factor.

Both channels are chopped, so the first period after a start yields no usable word. The first ready strobe comes only after two full periods. A pulse on the configuration-change input marks a switch of the excitation or burnout currents. Such a switch does not restart conversion. Instead, the block lowers a settled flag, which stays low for the next three output words.

The sequencing is done by two small state machines. The chop machine has the states CH_IDLE, CH_FILL and CH_RUN, with these transitions:
- start: CH_IDLE to CH_FILL, when either channel becomes active.
- fill_done: CH_FILL to CH_RUN, at the end of the first period.
- stop: from CH_FILL or CH_RUN back to CH_IDLE, when both channels drop.

The settle machine has the states ST_STEADY and ST_BLANK, with these transitions:
- disturb: ST_STEADY to ST_BLANK, on a configuration change.
- reload: ST_BLANK to ST_BLANK, on a configuration change while blanking.
- recover: ST_BLANK to ST_STEADY, when the third ready strobe is consumed.

Top module: `conv_rate_seq`

## Requirements
- R1: After reset the factor reads 69 (0x45), `rdy` is low and `settled` is high.
- R2: While both channels are idle, a write stores `wr_data`. A value below 13 is stored as 13. `rd_data` always shows the stored factor.
- R3: A write is ignored while `main_active` or `aux_active` is high. The factor read back is unchanged.
- R4: Let the first active clock edge after an idle spell be edge 1. The first `rdy` pulse is high in the cycle after edge 2·24·SF. No `rdy` occurs during the first period.
- R5: After the first pulse, `rdy` repeats every 24·SF cycles, and each pulse lasts exactly one cycle.
- R6: When both active inputs go low, the period count clears. The next start again waits two full periods before its first `rdy`.
- R7: A `cfg_change` pulse drives `settled` low in the following cycle. It leaves the `rdy` timing untouched.
- R8: `settled` rises one cycle after the third `rdy` pulse that follows the latest `cfg_change`. A new `cfg_change` during blanking restarts the count of three.
- R9: Either active input alone runs the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Factor write strobe |
| wr_data | input | 8 | Factor write value |
| rd_data | output | 8 | Stored decimation factor |
| main_active | input | 1 | Main channel converting |
| aux_active | input | 1 | Auxiliary channel converting |
| cfg_change | input | 1 | One-cycle pulse: excitation configuration switched |
| rdy | output | 1 | One-cycle strobe, output word ready |
| settled | output | 1 | High when the current word is fully settled |

## Verification
The assertions assume that `cfg_change` is a single-cycle pulse. They also assume the factor cannot change during a run, which follows from the write lock. Because the factor never drops below 13, the period is at least 312 cycles, and the one-cycle strobe check depends on that. The stimulus pulses `cfg_change` for exactly one cycle, well apart from any `rdy` strobe. It changes the factor only while both channels are idle. Writes issued during a run are used only to show that they are ignored.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_FILL = 2'd1,
        CH_RUN  = 2'd2
    } chop_state_t;

    typedef enum logic {
        ST_STEADY = 1'b0,
        ST_BLANK  = 1'b1
    } settle_state_t;
endpackage

// File: rtl/crs_factor_reg.sv
module crs_factor_reg #(
    parameter int W    = 8,
    parameter int FMIN = 13,
    parameter int FRST = 69
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         busy,
    output logic [W-1:0] sf_q
);
    localparam logic [W-1:0] FMIN_V = W'(FMIN);
    localparam logic [W-1:0] FRST_V = W'(FRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_q <= FRST_V;
        end else if (wr_en && !busy) begin
            sf_q <= (wr_data < FMIN_V) ? FMIN_V : wr_data;
        end
    end

    // R3: factor frozen while a channel converts
    a_r3_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sf_q));
    // R2: stored factor never below the floor
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        sf_q >= FMIN_V);
endmodule

// File: rtl/crs_period_timer.sv
module crs_period_timer #(
    parameter int W    = 8,
    parameter int MULT = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] sf,
    output logic         last
);
    localparam int CW = $clog2(MULT * (2 ** W));

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period_len;

    assign period_len = CW'(MULT) * CW'(sf);
    assign last       = run && (cnt_q == period_len - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R6: idle clears the period count
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/crs_chop_fsm.sv
module crs_chop_fsm
    import crs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic last,
    output logic rdy
);
    chop_state_t state_q, state_d;
    logic        rdy_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (run) state_d = CH_FILL;
            CH_FILL: begin
                if (!run)      state_d = CH_IDLE;
                else if (last) state_d = CH_RUN;
            end
            CH_RUN:  if (!run) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= (state_q == CH_RUN) && run && last;
    end

    assign rdy = rdy_q;

    // R4: no word while the chop fill period runs
    a_r4_no_early_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_RUN) |=> !rdy_q);
    // R5: strobe lasts one cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> !rdy_q);
endmodule

// File: rtl/crs_settle_fsm.sv
module crs_settle_fsm
    import crs_pkg::*;
#(
    parameter int SETTLE_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_change,
    input  logic rdy,
    output logic settled
);
    localparam int CNW = $clog2(SETTLE_N + 1);

    settle_state_t  state_q, state_d;
    logic [CNW-1:0] left_q;
    logic           settled_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY: if (cfg_change) state_d = ST_BLANK;
            ST_BLANK: begin
                if (cfg_change)                       state_d = ST_BLANK;
                else if (rdy && left_q == CNW'(1))    state_d = ST_STEADY;
            end
            default: state_d = ST_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_change)
                left_q <= CNW'(SETTLE_N);
            else if (state_q == ST_BLANK && rdy)
                left_q <= left_q - CNW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) settled_q <= 1'b1;
        else        settled_q <= (state_d == ST_STEADY);
    end

    assign settled = settled_q;

    // R7: change drops the flag next cycle
    a_r7_blank_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> !settled_q);
    // R8: flag only recovers on a consumed strobe
    a_r8_rise_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (!settled_q && !rdy) |=> !settled_q);
endmodule

// File: rtl/conv_rate_seq.sv
module conv_rate_seq #(
    parameter int W        = 8,
    parameter int MULT     = 24,
    parameter int FMIN     = 13,
    parameter int FRST     = 69,
    parameter int SETTLE_N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         main_active,
    input  logic         aux_active,
    input  logic         cfg_change,
    output logic         rdy,
    output logic         settled
);
    logic         run;
    logic [W-1:0] sf;
    logic         last;

    // R9: either channel runs the sequencer
    assign run     = main_active | aux_active;
    assign rd_data = sf;

    crs_factor_reg #(.W(W), .FMIN(FMIN), .FRST(FRST)) u_factor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .busy(run), .sf_q(sf)
    );

    crs_period_timer #(.W(W), .MULT(MULT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .sf(sf), .last(last)
    );

    crs_chop_fsm u_chop (
        .clk(clk), .rst_n(rst_n), .run(run), .last(last), .rdy(rdy)
    );

    crs_settle_fsm #(.SETTLE_N(SETTLE_N)) u_settle (
        .clk(clk), .rst_n(rst_n), .cfg_change(cfg_change), .rdy(rdy),
        .settled(settled)
    );

    // R1: quiet outputs right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rdy && settled));
endmodule

// File: tb/test_conv_rate_seq.sv
module test_conv_rate_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       main_active = 1'b0;
    logic       aux_active = 1'b0;
    logic       cfg_change = 1'b0;
    logic       rdy;
    logic       settled;

    always #2 clk = ~clk;

    conv_rate_seq i_conv_rate_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .main_active(main_active), .aux_active(aux_active),
        .cfg_change(cfg_change), .rdy(rdy), .settled(settled)
    );

    typedef struct {
        int unsigned cyc;
        logic        setl;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: queue the expected strobes of one run
    task automatic expect_rdys(input int unsigned start, input int p, input int n,
                               input int lo, input int hi, input string req);
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.cyc  = start + (k + 1) * p - 1;
            e.setl = !(k >= lo && k <= hi);
            e.req  = req;
            sb.push_back(e);
        end
    endtask

    task automatic write_sf(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_cfg;
        cfg_change = 1'b1;
        @(negedge clk);
        cfg_change = 1'b0;
        check(settled == 1'b0, "R7 settled low after change", settled, 0);
    endtask

    // monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (rst_n && !done && rdy) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected rdy", cyc, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.cyc, {e.req, " rdy cycle"}, cyc, e.cyc);
                check(settled == e.setl, "R8 settled at rdy", settled, e.setl);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned st;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'd69, "R1 reset factor", rd_data, 69);
        check(rdy == 1'b0, "R1 reset rdy", rdy, 0);
        check(settled == 1'b1, "R1 reset settled", settled, 1);

        write_sf(8'd200);
        check(rd_data == 8'd200, "R2 idle write", rd_data, 200);
        write_sf(8'd5);
        check(rd_data == 8'd13, "R2 clamp low", rd_data, 13);
        write_sf(8'd12);
        check(rd_data == 8'd13, "R2 clamp edge", rd_data, 13);
        write_sf(8'd13);
        check(rd_data == 8'd13, "R2 exact floor", rd_data, 13);

        // run 1: main only, period 312
        st = cyc + 1;
        expect_rdys(st, 312, 3, 99, 0, "R4 R5 main");
        main_active = 1'b1;
        repeat (50) @(negedge clk);
        write_sf(8'd99);
        check(rd_data == 8'd13, "R3 locked main", rd_data, 13);
        wait_until(st + 4 * 312 + 10);
        main_active = 1'b0;
        @(negedge clk);
        check(sb.size() == 0, "R5 all strobes seen run1", sb.size(), 0);
        check(rdy == 1'b0, "R6 quiet after stop", rdy, 0);

        write_sf(8'd14);
        check(rd_data == 8'd14, "R2 write after stop", rd_data, 14);

        // run 2: aux only, period 336, two excitation changes
        st = cyc + 1;
        expect_rdys(st, 336, 7, 3, 6, "R6 R9 aux");
        aux_active = 1'b1;
        repeat (20) @(negedge clk);
        write_sf(8'd40);
        check(rd_data == 8'd14, "R3 locked aux", rd_data, 14);
        wait_until(st + 3 * 336 + 20);
        pulse_cfg();
        wait_until(st + 4 * 336 + 20);
        pulse_cfg();
        wait_until(st + 8 * 336 + 5);
        check(settled == 1'b1, "R8 settled restored", settled, 1);
        aux_active = 1'b0;
        @(negedge clk);
        check(sb.size() == 0, "R5 all strobes seen run2", sb.size(), 0);

        // run 3: both channels, short restart check
        st = cyc + 1;
        expect_rdys(st, 336, 1, 99, 0, "R6 restart");
        main_active = 1'b1;
        aux_active  = 1'b1;
        wait_until(st + 3 * 336 - 20);
        main_active = 1'b0;
        aux_active  = 1'b0;
        @(negedge clk);
        check(sb.size() == 0, "R6 restart strobe seen", sb.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule